// File: doc/BRIEF.md
# Sprite Attribute Page Copy Engine

This block copies one whole page of CPU address space into the video processor's sprite attribute memory. Software starts a copy with one byte write to the trigger port. The byte is a page number N, so the copy reads from address N×256. The engine asserts a stall output to hold the CPU off the bus. It then masters the CPU bus itself, reading one source byte at a time, and pushes each byte into the video processor's sprite data port.

The sprite data port advances its own internal address after every write. The destination therefore wraps modulo 256 from wherever software last left that address. The engine never drives a destination address. Any page is a valid source, whether internal RAM (page 2 is the usual choice), cartridge RAM or cartridge ROM.

The bus master side uses a read strobe and a grant. While the strobe is high and grant is low, the read stretches, and the address and strobe hold steady. When the final byte has been written, stall drops and a single-cycle completion pulse appears.

Top module: `sprite_page_dma`

## Requirements
- R1: While reset is applied, and after it until a trigger arrives, stall, bus_rd, spr_we and done are all 0.
- R2: A trigger write (trig_we high at a clock edge while idle) raises stall in the next cycle. In that same cycle the first read is presented: bus_rd is 1 and bus_addr = trig_page×256.
- R3: The reads cover bus_addr = N×256 + k for k = 0 to 255, in ascending order, each address exactly once. N is the page that was latched.
- R4: Exactly 256 sprite port writes occur per transfer. Write number k carries the byte that was returned on bus_rdata for address N×256 + k.
- R5: Each byte takes one granted read cycle followed directly by one write cycle. With grant held high, stall stays high for exactly 512 cycles. bus_rd and spr_we are only ever high while stall is high.
- R6: While bus_rd is high and bus_gnt is low, the next cycle keeps bus_rd high, keeps the same bus_addr and has no sprite write.
- R7: A trigger write during a transfer is ignored. The source page, the address sequence and the write count of the running transfer are unchanged.
- R8: done is high for exactly one cycle, in the cycle right after the final sprite write, and stall is 0 in that cycle.
- R9: Every page value 0 to 255 is accepted as a source, including page 0 and page 255.
- R10: bus_rd and spr_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_we | input | 1 | Write strobe of the trigger register |
| trig_page | input | 8 | Byte written to the trigger register: the source page number |
| stall | output | 1 | Holds the CPU off the bus while a transfer runs |
| bus_addr | output | 16 | CPU bus address driven by the engine |
| bus_rd | output | 1 | Read strobe on the CPU bus |
| bus_rdata | input | 8 | Read data, valid in the cycle the read is granted |
| bus_gnt | input | 1 | Bus grant; completes the current read |
| spr_we | output | 1 | Write strobe to the sprite data port |
| spr_wdata | output | 8 | Byte written to the sprite data port |
| done | output | 1 | Single-cycle transfer-complete pulse |

## Verification
The assertions rely on three things about the inputs.
- bus_rdata is valid in the same cycle that bus_gnt is high with bus_rd.
- Grant always comes eventually.
- No trigger is issued in the two cycles after reset release, while the internal reset synchronizer is still holding the engine idle.

The bench models memory as a combinational function of bus_addr. It waits well past reset release before its first trigger. It sweeps all 256 source pages with grant held high, then repeats selected pages with a pseudo-random grant pattern and with stray triggers injected mid-transfer.

// File: rtl/spdma_pkg.sv
package spdma_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_FETCH = 2'd1,
    XF_STORE = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/spdma_rst_sync.sv
module spdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/spdma_seq.sv
module spdma_seq
  import spdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_we,
  input  logic bus_gnt,
  input  logic last_byte,
  output logic load_page,
  output logic capture,
  output logic advance,
  output logic busy,
  output logic rd_strobe,
  output logic wr_strobe,
  output logic done
);

  xfer_state_e state_q, state_d;
  logic        done_q, done_d;

  // Next-state and output decode.
  always_comb begin
    state_d   = state_q;
    load_page = 1'b0;
    capture   = 1'b0;
    advance   = 1'b0;
    rd_strobe = 1'b0;
    wr_strobe = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      XF_IDLE: begin
        if (trig_we) begin
          load_page = 1'b1;
          state_d   = XF_FETCH;
        end
      end
      XF_FETCH: begin
        rd_strobe = 1'b1;
        if (bus_gnt) begin
          capture = 1'b1;
          state_d = XF_STORE;
        end
      end
      XF_STORE: begin
        wr_strobe = 1'b1;
        advance   = 1'b1;
        if (last_byte) begin
          done_d  = 1'b1;
          state_d = XF_IDLE;
        end else begin
          state_d = XF_FETCH;
        end
      end
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q != XF_IDLE);
  assign done = done_q;

endmodule

// File: rtl/spdma_addr_gen.sv
module spdma_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_page,
  input  logic [PAGE_W-1:0]       page_in,
  input  logic                    advance,
  output logic [PAGE_W+IDX_W-1:0] src_addr,
  output logic                    last_byte
);

  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  logic [PAGE_W-1:0] page_q, page_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              page_en, idx_en;

  always_comb begin
    page_en = load_page;
    page_d  = page_in;
    idx_en  = load_page | advance;
    idx_d   = load_page ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      idx_q  <= '0;
    end else begin
      if (page_en) page_q <= page_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  assign src_addr  = {page_q, idx_q};
  assign last_byte = (idx_q == IDX_LAST);

endmodule

// File: rtl/spdma_data_hold.sv
module spdma_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    hold_en = capture;
    hold_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign dout = hold_q;

endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int IDX_W  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [PAGE_W-1:0] trig_page,
  output logic              stall,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_gnt,
  output logic              spr_we,
  output logic [DATA_W-1:0] spr_wdata,
  output logic              done
);

  logic rst_int_n;
  logic load_page, capture, advance, last_byte;

  spdma_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  spdma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trig_we   (trig_we),
    .bus_gnt   (bus_gnt),
    .last_byte (last_byte),
    .load_page (load_page),
    .capture   (capture),
    .advance   (advance),
    .busy      (stall),
    .rd_strobe (bus_rd),
    .wr_strobe (spr_we),
    .done      (done)
  );

  spdma_addr_gen #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_page (load_page),
    .page_in   (trig_page),
    .advance   (advance),
    .src_addr  (bus_addr),
    .last_byte (last_byte)
  );

  spdma_data_hold #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .capture (capture),
    .din     (bus_rdata),
    .dout    (spr_wdata)
  );

endmodule

// File: rtl/spdma_chk.sv
module spdma_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_we,
  input logic              stall,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_gnt,
  input logic              spr_we,
  input logic              done
);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && spr_we)); // R10
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd || spr_we) |-> stall); // R5
  AST_GRANT_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && bus_gnt) |=> spr_we); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && !bus_gnt) |=> (bus_rd && !spr_we && $stable(bus_addr))); // R6
  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) spr_we |=> (bus_rd || done)); // R5
  AST_START_STALL: assert property (@(posedge clk) disable iff (!rst_n) (trig_we && !stall) |=> (stall && bus_rd)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !stall); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (stall && bus_rd) |=> (!stall || bus_addr[ADDR_W-1:ADDR_W-PAGE_W] == $past(bus_addr[ADDR_W-1:ADDR_W-PAGE_W]))); // R7

endmodule

bind sprite_page_dma spdma_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig_we  (trig_we),
  .stall    (stall),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_gnt  (bus_gnt),
  .spr_we   (spr_we),
  .done     (done)
);

// File: tb/sim_sprite_page_dma.sv
`timescale 1ns/1ps
module sim_sprite_page_dma;

  logic        clk;
  logic        rst_n;
  logic        trig_we;
  logic [7:0]  trig_page;
  logic        stall;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic        bus_gnt;
  logic        spr_we;
  logic [7:0]  spr_wdata;
  logic        done;

  int n_vec, n_bad, cyc;
  int exp_page, wr_idx, stall_cnt, done_cnt;
  bit active, done_seen, prev_we, prev_wait;
  logic [15:0] prev_addr;
  logic [15:0] lfsr;

  sprite_page_dma u0 (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_page(trig_page),
    .stall(stall), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_gnt(bus_gnt), .spr_we(spr_we), .spr_wdata(spr_wdata), .done(done)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return 8'(a[15:8] * 7 + a[7:0] * 13 + 1);
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // Output monitor, sampling on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!active) begin
        if (bus_rd || spr_we) chk(1'b0, "R5 strobe while idle", {bus_rd, spr_we}, 0);
      end else begin
        chk(!(bus_rd && spr_we), "R10", {bus_rd, spr_we}, 2'b10);
        if (prev_wait)
          chk(bus_rd && !spr_we && bus_addr == prev_addr, "R6", bus_addr, prev_addr);
        if (stall) stall_cnt++;
        if (bus_rd)
          chk(bus_addr == {exp_page[7:0], wr_idx[7:0]} && wr_idx < 256, "R3 R7 address",
              bus_addr, {exp_page[7:0], wr_idx[7:0]});
        if (spr_we) begin
          chk(wr_idx < 256 && spr_wdata == mem_val({exp_page[7:0], wr_idx[7:0]}), "R4 data",
              spr_wdata, mem_val({exp_page[7:0], wr_idx[7:0]}));
          wr_idx++;
        end
        if (done) begin
          done_cnt++;
          done_seen = 1'b1;
          chk(prev_we && wr_idx == 256 && !stall, "R8", {prev_we, stall}, 2'b10);
        end
      end
      prev_we   = spr_we;
      prev_wait = bus_rd && !bus_gnt;
      prev_addr = bus_addr;
    end
  end

  task automatic run_xfer(input int page, input bit rand_gnt, input int inject_at);
    int k;
    exp_page = page; wr_idx = 0; stall_cnt = 0; done_cnt = 0; done_seen = 1'b0;
    @(posedge clk); #1;
    trig_we = 1'b1; trig_page = page[7:0]; active = 1'b1;
    @(posedge clk); #1;
    trig_we = 1'b0;
    @(negedge clk);
    chk(stall && bus_rd && bus_addr == {page[7:0], 8'h00}, "R2", bus_addr, {page[7:0], 8'h00});
    k = 0;
    while (!done_seen && k < 3000) begin
      @(posedge clk); #1;
      k++;
      if (rand_gnt) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_gnt = lfsr[0] | lfsr[3];
      end
      trig_we = (inject_at != 0) && (k == inject_at || k == inject_at + 7);
      trig_page = ~page[7:0];
    end
    trig_we = 1'b0; bus_gnt = 1'b1;
    @(negedge clk);
    chk(wr_idx == 256, "R4 count", wr_idx, 256);
    chk(done_cnt == 1, "R8 pulse count", done_cnt, 1);
    if (!rand_gnt) chk(stall_cnt == 512, "R5 stall length", stall_cnt, 512);
    chk(!stall && !done, "R8 idle after", {stall, done}, 0);
    active = 1'b0;
  endtask

  initial begin
    n_vec = 0; n_bad = 0; cyc = 0; active = 1'b0; prev_we = 1'b0; prev_wait = 1'b0;
    prev_addr = '0; lfsr = 16'hACE1;
    rst_n = 1'b0; trig_we = 1'b0; trig_page = '0; bus_gnt = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!stall && !bus_rd && !spr_we && !done, "R1 in reset", {stall, bus_rd, spr_we, done}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!stall && !bus_rd && !spr_we && !done, "R1 after release", {stall, bus_rd, spr_we, done}, 0);
    // R9: every page, grant held high
    for (int p = 0; p < 256; p++) run_xfer(p, 1'b0, 0);
    // R6: stretched reads
    run_xfer(2, 1'b1, 0);
    run_xfer(255, 1'b1, 0);
    // R7: stray triggers mid-transfer
    run_xfer(2, 1'b0, 100);
    run_xfer(128, 1'b1, 301);
    run_xfer(0, 1'b0, 510);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule